// File: doc/BRIEF.md
# Multi-Domain Scan Capture Clock Sequencer

This block owns the clock outputs of several clock domains while a chip is under scan test. With test mode off, every domain output carries that domain's own functional clock. With test mode on and scan enable high, the slow test clock from a primary input reaches every domain, so all chains shift together. When scan enable drops, the block runs a capture sequence. It visits the domains in ascending index order and gives each enabled domain its capture pulses in a slot of its own. No two slots overlap, and a programmable gap of idle test-clock cycles sits before each slot.

Two capture styles are offered. Slow capture gives each enabled domain one pulse of the test clock. At-speed capture gives each enabled domain two back-to-back pulses of the fast internal clock, one to launch and one to capture. A two-flop synchroniser carries the request into the fast domain, and a handshake carries completion back. Every output is gated by a latch-transparent-low enable, so a pulse is either whole or absent. Configuration comes in through a small write-only register port that stands in for a test-access data register. Reasserting scan enable in the middle of a sequence abandons it and returns to shifting.

Top module: `msc_capture_seq`

## Requirements
- R1: With test_mode low, each dom_clk[d] reproduces func_clk[d] edge for edge once two func_clk[d] edges have passed. No test-clock or fast-clock pulse appears, and no capture sequence starts, even with at-speed enabled and scan_en toggling.
- R2: With test_mode high and scan_en held high, every dom_clk output pulses once in each clk cycle, high during the high phase of clk.
- R3: A capture sequence starts in the clk cycle after scan_en is sampled low, having been high one cycle earlier. Enabled domains are served strictly in ascending index order, and in slow capture each enabled domain receives exactly one pulse.
- R4: Bit d of the mask register (address 0) enables domain d. A domain whose bit is 0 receives no capture pulse, and an all-zero mask finishes the sequence at once without any pulse.
- R5: In slow capture with gap value G (address 1), the first domain's pulse comes exactly G+2 clk cycles after the clk edge that starts the sequence. Successive domains' pulses are at least G+1 clk cycles apart.
- R6: With bit 0 of the control register (address 2) set, each enabled domain receives exactly two fast_clk pulses, both within one clk period and none from clk. The domain index sent to the fast side stays stable while the request is up.
- R7: During a capture sequence at most one dom_clk output is high at any instant, and slow and fast pulsing never happen together.
- R8: cap_busy is high from the clk edge that starts the sequence until the last domain has been served. cap_done then stays high until scan_en rises and clears in the following cycle.
- R9: If scan_en rises during a sequence, cap_busy falls at the next clk edge, the remaining domains get no capture pulse, and shift pulses resume one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow test clock from a primary input; also clocks the sequencer |
| fast_clk | input | 1 | Fast internal clock used for at-speed pulses |
| func_clk | input | N_DOM | Functional clock of each domain |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Selects test clocking (1) or functional clocking (0) |
| scan_en | input | 1 | Shift (1) or capture (0) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Register select: 0 mask, 1 gap, 2 control |
| cfg_wdata | input | CFG_DW | Configuration write data |
| dom_clk | output | N_DOM | Clock delivered to each domain |
| cap_busy | output | 1 | Capture sequence in progress |
| cap_done | output | 1 | Capture sequence finished, waiting for scan_en |

## Verification
The hardest situation to reach from the ports is a scan_en reassertion that lands inside a running sequence, after one domain has been pulsed but before the next slot opens. The bench sets a long gap, watches the first domain's output until it has pulsed, and then raises scan_en during the wait. It also confirms that the at-speed pair arrives as two pulses inside a single test-clock period, with non-overlap watched on every output change.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int DOM_N  = 4;
    localparam int GAP_W  = 8;
    localparam int CFG_AW = 2;
    localparam int CFG_DW = 8;

    localparam logic [CFG_AW-1:0] ADR_MASK = 2'd0;
    localparam logic [CFG_AW-1:0] ADR_GAP  = 2'd1;
    localparam logic [CFG_AW-1:0] ADR_CTRL = 2'd2;

    typedef enum logic [2:0] {
        ST_SHIFT,
        ST_GAP,
        ST_SLOW,
        ST_FREQ,
        ST_FWAIT,
        ST_DONE
    } seq_st_e;

    // lowest enabled domain index at or above 'from'; n when none is left
    function automatic int next_dom(input logic [31:0] m, input int from, input int n);
        int r;
        r = n;
        for (int i = n - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/msc_cfg_regs.sv
module msc_cfg_regs #(
    parameter int N  = 4,
    parameter int GW = 8,
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  mask,
    output logic [GW-1:0] gap,
    output logic          atspeed
);
    import msc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask    <= '1;
            gap     <= '0;
            atspeed <= 1'b0;
        end else if (we) begin
            case (addr)
                ADR_MASK: mask    <= wdata[N-1:0];
                ADR_GAP:  gap     <= wdata[GW-1:0];
                ADR_CTRL: atspeed <= wdata[0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/msc_clk_gate.sv
module msc_clk_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_l;

    // enable may only move while the clock is low
    always_latch begin
        if (!clk_in) en_l = en;
    end

    assign clk_out = clk_in & en_l;

endmodule

// File: rtl/msc_slot_fsm.sv
module msc_slot_fsm #(
    parameter int N  = 4,
    parameter int GW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test_mode,
    input  logic          scan_en,
    input  logic [N-1:0]  mask,
    input  logic [GW-1:0] gap,
    input  logic          atspeed,
    input  logic          fast_ack,
    output logic [N-1:0]  slow_en,
    output logic          fast_req,
    output logic [IW-1:0] fast_dom,
    output logic          test_q,
    output logic          busy,
    output logic          done
);
    import msc_pkg::*;

    seq_st_e       st;
    logic          se_q;
    logic [IW-1:0] dom;
    logic [GW-1:0] cnt;
    logic          req_q;
    logic          ack_m, ack_s;
    int            nd;

    always_comb begin
        logic [31:0] m32;
        m32 = '0;
        m32[N-1:0] = mask;
        nd = next_dom(m32, (st == ST_SHIFT) ? 0 : int'(dom) + 1, N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_SHIFT;
            se_q   <= 1'b0;
            test_q <= 1'b0;
            dom    <= '0;
            cnt    <= '0;
            req_q  <= 1'b0;
            ack_m  <= 1'b0;
            ack_s  <= 1'b0;
        end else begin
            se_q   <= scan_en;
            test_q <= test_mode;
            ack_m  <= fast_ack;
            ack_s  <= ack_m;
            if (!test_q) begin
                st    <= ST_SHIFT;
                req_q <= 1'b0;
            end else if (scan_en && st != ST_SHIFT) begin
                st    <= ST_SHIFT;
                req_q <= 1'b0;
            end else begin
                case (st)
                    ST_SHIFT: begin
                        if (se_q && !scan_en && !ack_s) begin
                            if (nd >= N) st <= ST_DONE;
                            else begin
                                dom <= IW'(nd);
                                cnt <= gap;
                                st  <= ST_GAP;
                            end
                        end
                    end
                    ST_GAP: begin
                        if (cnt == '0) begin
                            if (atspeed) begin
                                st    <= ST_FREQ;
                                req_q <= 1'b1;
                            end else begin
                                st <= ST_SLOW;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_FREQ: begin
                        if (ack_s) begin
                            req_q <= 1'b0;
                            st    <= ST_FWAIT;
                        end
                    end
                    ST_SLOW, ST_FWAIT: begin
                        if (st == ST_SLOW || !ack_s) begin
                            if (nd >= N) st <= ST_DONE;
                            else begin
                                dom <= IW'(nd);
                                cnt <= gap;
                                st  <= ST_GAP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        slow_en = '0;
        if (test_q && st == ST_SHIFT && se_q) slow_en = '1;
        else if (test_q && st == ST_SLOW)    slow_en[dom] = 1'b1;
    end

    assign fast_req = req_q;
    assign fast_dom = dom;
    assign busy     = (st == ST_GAP) || (st == ST_SLOW) || (st == ST_FREQ) || (st == ST_FWAIT);
    assign done     = (st == ST_DONE);

endmodule

// File: rtl/msc_fast_pulser.sv
module msc_fast_pulser #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          fast_clk,
    input  logic          rst,
    input  logic          req,
    input  logic [IW-1:0] dom,
    output logic          ack,
    output logic [N-1:0]  fast_en
);
    logic rq_m, rq_s;
    logic run, ph, done_q;

    always_ff @(posedge fast_clk) begin
        if (rst) begin
            rq_m   <= 1'b0;
            rq_s   <= 1'b0;
            run    <= 1'b0;
            ph     <= 1'b0;
            done_q <= 1'b0;
        end else begin
            rq_m <= req;
            rq_s <= rq_m;
            if (run) begin
                ph <= 1'b1;
                if (ph) begin
                    run    <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (!done_q && rq_s) begin
                run <= 1'b1;
                ph  <= 1'b0;
            end else if (done_q && !rq_s) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        fast_en = '0;
        if (run) fast_en[dom] = 1'b1;
    end

    assign ack = done_q;

endmodule

// File: rtl/msc_capture_seq.sv
module msc_capture_seq #(
    parameter int N_DOM  = msc_pkg::DOM_N,
    parameter int GAP_W  = msc_pkg::GAP_W,
    parameter int CFG_AW = msc_pkg::CFG_AW,
    parameter int CFG_DW = msc_pkg::CFG_DW
) (
    input  logic              clk,
    input  logic              fast_clk,
    input  logic [N_DOM-1:0]  func_clk,
    input  logic              rst,
    input  logic              test_mode,
    input  logic              scan_en,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [N_DOM-1:0]  dom_clk,
    output logic              cap_busy,
    output logic              cap_done
);
    localparam int IW = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    logic [N_DOM-1:0] cfg_mask;
    logic [GAP_W-1:0] cfg_gap;
    logic             cfg_atspeed;
    logic [N_DOM-1:0] slow_en, fast_en;
    logic             fast_req, fast_ack, test_q;
    logic [IW-1:0]    fast_dom;

    msc_cfg_regs #(.N(N_DOM), .GW(GAP_W), .AW(CFG_AW), .DW(CFG_DW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .mask(cfg_mask), .gap(cfg_gap), .atspeed(cfg_atspeed)
    );

    msc_slot_fsm #(.N(N_DOM), .GW(GAP_W)) u_fsm (
        .clk(clk), .rst(rst), .test_mode(test_mode), .scan_en(scan_en),
        .mask(cfg_mask), .gap(cfg_gap), .atspeed(cfg_atspeed), .fast_ack(fast_ack),
        .slow_en(slow_en), .fast_req(fast_req), .fast_dom(fast_dom), .test_q(test_q),
        .busy(cap_busy), .done(cap_done)
    );

    msc_fast_pulser #(.N(N_DOM)) u_fast (
        .fast_clk(fast_clk), .rst(rst), .req(fast_req), .dom(fast_dom),
        .ack(fast_ack), .fast_en(fast_en)
    );

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        logic [1:0] fsync;
        logic       s_clk, f_clk, u_clk;

        // functional enable is brought into the domain's own clock
        always_ff @(posedge func_clk[d]) begin
            if (rst) fsync <= '0;
            else     fsync <= {fsync[0], ~test_mode};
        end

        msc_clk_gate u_slow (.clk_in(clk),         .en(slow_en[d]), .clk_out(s_clk));
        msc_clk_gate u_fst  (.clk_in(fast_clk),    .en(fast_en[d]), .clk_out(f_clk));
        msc_clk_gate u_func (.clk_in(func_clk[d]), .en(fsync[1]),   .clk_out(u_clk));

        assign dom_clk[d] = s_clk | f_clk | u_clk;
    end

endmodule

// File: rtl/msc_capture_seq_chk.sv
module msc_capture_seq_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          scan_en,
    input logic          test_q,
    input logic [N-1:0]  slow_en,
    input logic          fast_req,
    input logic [IW-1:0] fast_dom,
    input logic          busy,
    input logic          done,
    input logic [N-1:0]  mask
);
    AST_FUNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !test_q |-> (slow_en == '0 && !fast_req)); // R1
    AST_SLOW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> $onehot0(slow_en)); // R7
    AST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
        fast_req |-> (slow_en == '0)); // R7
    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((slow_en & ~mask) == '0)); // R4
    AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (busy && scan_en) |=> !busy); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !scan_en && test_q) |=> done); // R8
    AST_REQ_DOM_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fast_req && $past(fast_req)) |-> $stable(fast_dom)); // R6
endmodule

bind msc_capture_seq msc_capture_seq_chk #(.N(N_DOM), .IW(IW)) chk_i (
    .clk(clk), .rst(rst), .scan_en(scan_en), .test_q(test_q), .slow_en(slow_en),
    .fast_req(fast_req), .fast_dom(fast_dom), .busy(cap_busy), .done(cap_done),
    .mask(cfg_mask)
);

// File: tb/msc_capture_seq_tb_top.sv
`timescale 1ns/1ps
module msc_capture_seq_tb_top;
    localparam int ND = 4;

    logic          clk = 1'b0, fast_clk = 1'b0, rst = 1'b1;
    logic          test_mode = 1'b0, scan_en = 1'b0, cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          fck [ND];
    logic [ND-1:0] func_clk, dom_clk;
    logic          cap_busy, cap_done;

    int       n_run = 0, n_fail = 0, ovl_err = 0;
    int       pc [ND];
    int       fc [ND];
    realtime  t1 [ND];
    realtime  t2 [ND];
    int       ord [$];
    bit       cap_win = 1'b0;
    realtime  t_start;

    always #5    clk = ~clk;
    always #1.3  fast_clk = ~fast_clk;

    for (genvar d = 0; d < ND; d++) begin : g_bench
        initial fck[d] = 1'b0;
        always #(3 + d) fck[d] = ~fck[d];
        assign func_clk[d] = fck[d];
        always @(posedge dom_clk[d]) begin
            pc[d]++;
            if (pc[d] == 1) begin
                t1[d] = $realtime;
                if (cap_win) ord.push_back(d);
            end
            if (pc[d] == 2) t2[d] = $realtime;
        end
        always @(posedge func_clk[d]) fc[d]++;
    end

    always @(dom_clk) if (cap_win && $countones(dom_clk) > 1) ovl_err++;

    msc_capture_seq dut_i (
        .clk(clk), .fast_clk(fast_clk), .func_clk(func_clk), .rst(rst),
        .test_mode(test_mode), .scan_en(scan_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .dom_clk(dom_clk),
        .cap_busy(cap_busy), .cap_done(cap_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int d = 0; d < ND; d++) begin pc[d] = 0; fc[d] = 0; end
        ord.delete();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drop scan_en and align counters to the starting clk edge
    task automatic start_capture();
        @(negedge clk);
        scan_en = 1'b0;
        @(posedge clk);
        t_start = $realtime;
        #2;
        clear_counts();
        cap_win = 1'b1;
    endtask

    task automatic run_capture(input logic [3:0] m, input int g, input bit fast);
        int exp_n, k;
        int exp_ord [$];
        wr(2'd0, {4'b0, m});
        wr(2'd1, 8'(g));
        wr(2'd2, {7'b0, fast});
        @(negedge clk); scan_en = 1'b1;
        repeat (3) @(negedge clk);
        start_capture();
        chk(cap_busy == (m != 0), "R8 busy at start", int'(cap_busy), int'(m != 0));
        chk(cap_done == (m == 0), "R4 done at start", int'(cap_done), int'(m == 0));
        k = 0;
        while (!cap_done && k < 3000) begin @(negedge clk); k++; end
        repeat (2) @(negedge clk);
        cap_win = 1'b0;
        exp_n = fast ? 2 : 1;
        for (int d = 0; d < ND; d++) begin
            chk(pc[d] == (m[d] ? exp_n : 0), m[d] ? (fast ? "R6 pulse count" : "R3 pulse count")
                : "R4 masked domain", pc[d], m[d] ? exp_n : 0);
            if (m[d]) exp_ord.push_back(d);
            if (m[d] && fast)
                chk((t2[d] - t1[d]) < 10.0, "R6 pair within one period",
                    int'(t2[d] - t1[d]), 10);
        end
        chk(ord.size() == exp_ord.size(), "R3 served count", ord.size(), exp_ord.size());
        for (int i = 0; i < ord.size() && i < exp_ord.size(); i++)
            chk(ord[i] == exp_ord[i], "R3 order", ord[i], exp_ord[i]);
        for (int i = 0; i + 1 < ord.size(); i++)
            chk((t1[ord[i+1]] - t1[ord[i]]) >= (g + 1) * 10.0 - 0.01, "R5 spacing",
                int'(t1[ord[i+1]] - t1[ord[i]]), (g + 1) * 10);
        if (!fast && ord.size() > 0)
            chk((t1[ord[0]] - t_start) == (g + 2) * 10.0, "R5 first pulse delay",
                int'(t1[ord[0]] - t_start), (g + 2) * 10);
        chk(ovl_err == 0, "R7 overlap", ovl_err, 0);
        chk(cap_done == 1'b1 && cap_busy == 1'b0, "R8 done held", int'(cap_done), 1);
        @(negedge clk); scan_en = 1'b1;
        @(posedge clk); #2;
        chk(cap_done == 1'b0, "R8 done clears", int'(cap_done), 0);
    endtask

    initial begin
        #500us;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        int k;
        for (int d = 0; d < ND; d++) begin pc[d] = 0; fc[d] = 0; end
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(cap_busy == 1'b0 && cap_done == 1'b0, "R8 reset state", int'(cap_busy), 0);

        // R1: functional pass-through, with capture attempts ignored
        wr(2'd2, 8'd1);
        #50.5;
        clear_counts();
        scan_en = 1'b1;
        #100;
        scan_en = 1'b0;
        #100;
        for (int d = 0; d < ND; d++)
            chk(pc[d] == fc[d], "R1 functional clock", pc[d], fc[d]);
        chk(cap_busy == 1'b0 && cap_done == 1'b0, "R1 no sequence", int'(cap_busy), 0);
        wr(2'd2, 8'd0);

        // R2: shift
        @(negedge clk);
        scan_en = 1'b1;
        test_mode = 1'b1;
        repeat (12) @(negedge clk);
        @(posedge clk); #2;
        clear_counts();
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            chk(dom_clk == '1, "R2 shift high phase", int'(dom_clk), 15);
        end
        #1;
        for (int d = 0; d < ND; d++)
            chk(pc[d] == 20, "R2 shift pulse count", pc[d], 20);

        // R3, R5: slow, all domains
        run_capture(4'b1111, 2, 1'b0);
        // R4: sparse mask, no gap
        run_capture(4'b1010, 0, 1'b0);
        // R4: empty mask
        run_capture(4'b0000, 3, 1'b0);
        // R6: at-speed
        run_capture(4'b0110, 1, 1'b1);
        run_capture(4'b1001, 0, 1'b1);

        // R9: abort between slots
        wr(2'd0, 8'h0f);
        wr(2'd1, 8'd20);
        wr(2'd2, 8'd0);
        @(negedge clk); scan_en = 1'b1;
        repeat (3) @(negedge clk);
        start_capture();
        k = 0;
        while (pc[0] == 0 && k < 100) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
        scan_en = 1'b1;
        cap_win = 1'b0;
        @(posedge clk); #2;
        chk(cap_busy == 1'b0, "R9 busy drops", int'(cap_busy), 0);
        chk(pc[1] + pc[2] + pc[3] == 0, "R9 no further capture", pc[1] + pc[2] + pc[3], 0);
        clear_counts();
        repeat (5) @(posedge clk);
        #2;
        for (int d = 0; d < ND; d++)
            chk(pc[d] == 5, "R9 shift resumes", pc[d], 5);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule